// File: doc/BRIEF.md
# Range-Matched Fully Associative Translation Buffer

This block holds a small set of address translations and answers lookups against them in the same cycle. Each slot stores an inclusive virtual window, given as a first and a last address, together with a physical page number, a protection descriptor and a valid flag. A lookup compares the address against every window in parallel. The lowest-numbered slot whose window contains the address supplies the result, whether that slot is valid or still waiting for its protection word.

Software fills a slot in two commands. A map command claims a slot, writes the window and the physical page, and leaves the slot invalid. A protect command for an address in that window then loads the descriptor and sets the slot valid. Two purge commands remove translations: one drops the single valid slot that covers an address, and the other empties the whole buffer. A map command first looks for a slot it can reuse. When there is none, it evicts the slot under a round-robin pointer. Every command is accepted in one cycle and takes effect at the next clock edge.

Top module: `range_tlb`

## Requirements
- R1: After reset every lookup misses: lk_hit, lk_valid and all lookup field outputs are zero, and prot_err is low.
- R2: A slot matches when its first address is at most lk_addr and lk_addr is at most its last address. The lowest matching index drives lk_idx and the field outputs, and lk_paddr is the slot's page number followed by the low 12 bits of lk_addr. On a miss all field outputs are zero.
- R3: A map command (cmd_op 0) writes first = cmd_addr with its low 12 bits cleared, last = first + 4095, and page number = cmd_data[24:5]. It leaves the slot invalid with a zero descriptor, so a lookup hits with lk_valid low.
- R4: A map command invalidates every valid slot whose window covers cmd_addr. Of the slots that are invalid or were just invalidated, it writes into the one with the highest index.
- R5: When a map command finds no such slot, it writes into the slot under the round-robin pointer. The pointer resets to 0, advances by one on each such eviction and wraps from 15 to 0.
- R6: A protect command (cmd_op 1) on a covering, invalid slot sets it valid and loads the descriptor. lk_prot[k] equals cmd_data[k+1] for k = 0..28, so the access id sits in data bits 1 to 18, the user bit in 19, the two privilege fields in 20 to 21 and 22 to 23, the access type in 24 to 26, and the break, dirty and trap bits in 27, 28 and 29.
- R7: A protect command is ignored, and prot_err is high for the one cycle after it, when no slot covers cmd_addr or when the first covering slot is already valid. prot_err is low at all other times.
- R8: A page purge (cmd_op 2) clears the first slot covering cmd_addr only if that slot is valid. A covering slot still waiting for its protect command is left unchanged.
- R9: A purge-all command (cmd_op 3) clears every slot, pending slots included, and leaves the round-robin pointer unchanged.
- R10: A cleared slot has its first address set to all ones and every other field set to zero, so it matches no address, address 0xFFFFFFFF included.
- R11: While cmd_valid is low no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some slot's window contains lk_addr |
| lk_valid | output | 1 | The selected slot is valid |
| lk_idx | output | 4 | Index of the selected slot |
| lk_ppn | output | 20 | Physical page number of the selected slot |
| lk_paddr | output | 32 | Page number joined with the address offset |
| lk_prot | output | 29 | Descriptor of the selected slot |
| lk_base | output | 32 | First address of the selected window |
| lk_limit | output | 32 | Last address of the selected window |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 map, 1 protect, 2 purge page, 3 purge all |
| cmd_addr | input | 32 | Command virtual address |
| cmd_data | input | 32 | Page number word or descriptor word |
| prot_err | output | 1 | Previous cycle held an ignored protect command |

## Verification
The bench fills the buffer one slot at a time and checks where each fill lands. A design that picks the lowest free slot, or that skips pending slots, puts the fills in the wrong places. Once the buffer is full, the bench keeps mapping new pages until the round-robin pointer wraps, so a pointer that never wraps or that is not reset gives the wrong slot indices. Remapping a page that is already valid must reuse the slot it invalidates, even when a lower free slot exists. Protect commands aimed at empty windows or at valid slots must leave the descriptor alone and pulse prot_err. A page purge must not clear a slot that is still pending. Lookups at window edges, one address outside each edge, and at 0 and 0xFFFFFFFF show up a comparison that is off by one or a cleared slot that still matches.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;

   typedef enum logic [1:0] {
      CMD_MAP       = 2'd0,
      CMD_PROT      = 2'd1,
      CMD_DROP_PAGE = 2'd2,
      CMD_DROP_ALL  = 2'd3
   } tlb_cmd_e;

   // descriptor; packed so that bit k maps to data word bit k+1
   typedef struct packed {
      logic        trap;
      logic        dirty;
      logic        brk;
      logic [2:0]  atype;
      logic [1:0]  pl_hi;
      logic [1:0]  pl_lo;
      logic        user;
      logic [17:0] aid;
   } tlb_prot_t;

   localparam int PROT_W = $bits(tlb_prot_t);

   function automatic tlb_prot_t unpack_prot(input logic [31:0] w);
      tlb_prot_t p;
      p.aid   = w[18:1];
      p.user  = w[19];
      p.pl_lo = w[21:20];
      p.pl_hi = w[23:22];
      p.atype = w[26:24];
      p.brk   = w[27];
      p.dirty = w[28];
      p.trap  = w[29];
      return p;
   endfunction

endpackage

// File: rtl/rtlb_range_cmp.sv
module rtlb_range_cmp #(
   parameter int N    = 16,
   parameter int VA_W = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [VA_W-1:0]  addr,
   input  logic [VA_W-1:0]  lo [N],
   input  logic [VA_W-1:0]  hi [N],
   output logic [N-1:0]     hit_vec,
   output logic             any_hit,
   output logic [IDX_W-1:0] first_idx
);

   // one inclusive window comparator per slot
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = (lo[g] <= addr) && (addr <= hi[g]);
   end

   // lowest index wins: scan downward so the last assignment is the lowest
   always_comb begin
      first_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) first_idx = IDX_W'(i);
      end
   end

   assign any_hit = |hit_vec;

endmodule

// File: rtl/rtlb_slot_pick.sv
module rtlb_slot_pick #(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid_vec,
   input  logic [N-1:0]     cover_vec,
   input  logic [IDX_W-1:0] rr_ptr,
   output logic [N-1:0]     kill_vec,
   output logic             use_free,
   output logic [IDX_W-1:0] slot_idx
);

   logic [N-1:0]     reusable;
   logic [IDX_W-1:0] free_idx;

   assign kill_vec = valid_vec & cover_vec;
   assign reusable = ~valid_vec | kill_vec;
   assign use_free = |reusable;

   // highest reusable index: ascending scan, last assignment wins
   always_comb begin
      free_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (reusable[i]) free_idx = IDX_W'(i);
      end
   end

   assign slot_idx = use_free ? free_idx : rr_ptr;

endmodule

// File: rtl/range_tlb.sv
module range_tlb
   import rtlb_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PPN_W     = 20,
   parameter int PPN_LSB   = 5,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int PA_W     = PPN_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_addr,
   output logic              lk_hit,
   output logic              lk_valid,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [PROT_W-1:0] lk_prot,
   output logic [VA_W-1:0]   lk_base,
   output logic [VA_W-1:0]   lk_limit,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [VA_W-1:0]   cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              prot_err
);

   initial begin
      assert (ENTRIES >= 2) else $error("range_tlb: ENTRIES must be at least 2");
      assert (DATA_W == 32) else $error("range_tlb: descriptor layout needs a 32-bit word");
      assert (PPN_LSB + PPN_W <= DATA_W) else $error("range_tlb: page number field exceeds data word");
      assert (PAGE_BITS < VA_W) else $error("range_tlb: page offset wider than address");
   end

   // slot storage
   logic [VA_W-1:0]   e_lo   [ENTRIES];
   logic [VA_W-1:0]   e_hi   [ENTRIES];
   logic [PPN_W-1:0]  e_ppn  [ENTRIES];
   tlb_prot_t         e_prot [ENTRIES];
   logic [ENTRIES-1:0] valid_vec;
   logic [IDX_W-1:0]  rr_ptr;

   tlb_cmd_e op_e;
   assign op_e = tlb_cmd_e'(cmd_op);

   // lookup side
   logic [ENTRIES-1:0] l_vec;
   logic               l_any;
   logic [IDX_W-1:0]   l_idx;

   rtlb_range_cmp #(.N(ENTRIES), .VA_W(VA_W)) u_lk_cmp (
      .addr(lk_addr), .lo(e_lo), .hi(e_hi),
      .hit_vec(l_vec), .any_hit(l_any), .first_idx(l_idx)
   );

   // command side
   logic [ENTRIES-1:0] c_vec;
   logic               c_any;
   logic [IDX_W-1:0]   c_idx;

   rtlb_range_cmp #(.N(ENTRIES), .VA_W(VA_W)) u_cmd_cmp (
      .addr(cmd_addr), .lo(e_lo), .hi(e_hi),
      .hit_vec(c_vec), .any_hit(c_any), .first_idx(c_idx)
   );

   logic [ENTRIES-1:0] kill_vec;
   logic               use_free;
   logic [IDX_W-1:0]   slot_idx;

   rtlb_slot_pick #(.N(ENTRIES)) u_pick (
      .valid_vec(valid_vec), .cover_vec(c_vec), .rr_ptr(rr_ptr),
      .kill_vec(kill_vec), .use_free(use_free), .slot_idx(slot_idx)
   );

   logic [IDX_W-1:0] rr_next;
   assign rr_next = (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;

   logic [VA_W-1:0] map_lo, map_hi;
   assign map_lo = {cmd_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
   assign map_hi = {cmd_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b1}}};

   logic prot_bad;
   assign prot_bad = !c_any || valid_vec[c_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            e_lo[i]   <= '1;
            e_hi[i]   <= '0;
            e_ppn[i]  <= '0;
            e_prot[i] <= '0;
         end
         valid_vec <= '0;
         rr_ptr    <= '0;
         prot_err  <= 1'b0;
      end else begin
         prot_err <= 1'b0;
         if (cmd_valid) begin
            unique case (op_e)
               CMD_MAP: begin
                  for (int i = 0; i < ENTRIES; i++) begin
                     if (kill_vec[i]) begin
                        e_lo[i]      <= '1;
                        e_hi[i]      <= '0;
                        e_ppn[i]     <= '0;
                        e_prot[i]    <= '0;
                        valid_vec[i] <= 1'b0;
                     end
                  end
                  e_lo[slot_idx]      <= map_lo;
                  e_hi[slot_idx]      <= map_hi;
                  e_ppn[slot_idx]     <= cmd_data[PPN_LSB +: PPN_W];
                  e_prot[slot_idx]    <= '0;
                  valid_vec[slot_idx] <= 1'b0;
                  if (!use_free) rr_ptr <= rr_next;
               end
               CMD_PROT: begin
                  if (prot_bad) begin
                     prot_err <= 1'b1;
                  end else begin
                     e_prot[c_idx]    <= unpack_prot(cmd_data);
                     valid_vec[c_idx] <= 1'b1;
                  end
               end
               CMD_DROP_PAGE: begin
                  if (c_any && valid_vec[c_idx]) begin
                     e_lo[c_idx]      <= '1;
                     e_hi[c_idx]      <= '0;
                     e_ppn[c_idx]     <= '0;
                     e_prot[c_idx]    <= '0;
                     valid_vec[c_idx] <= 1'b0;
                  end
               end
               CMD_DROP_ALL: begin
                  for (int i = 0; i < ENTRIES; i++) begin
                     e_lo[i]   <= '1;
                     e_hi[i]   <= '0;
                     e_ppn[i]  <= '0;
                     e_prot[i] <= '0;
                  end
                  valid_vec <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   // lookup outputs, zero on a miss
   assign lk_hit   = l_any;
   assign lk_idx   = l_idx;
   assign lk_valid = l_any && valid_vec[l_idx];
   assign lk_ppn   = l_any ? e_ppn[l_idx] : '0;
   assign lk_prot  = l_any ? e_prot[l_idx] : '0;
   assign lk_base  = l_any ? e_lo[l_idx] : '0;
   assign lk_limit = l_any ? e_hi[l_idx] : '0;
   assign lk_paddr = l_any ? {e_ppn[l_idx], lk_addr[PAGE_BITS-1:0]} : '0;

   // R2: a valid result always comes with a window hit
   a_r2_valid_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> lk_hit);

   // R3: mapping never raises the number of valid slots
   a_r3_map_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_e == CMD_MAP) |=> $countones(valid_vec) <= $past($countones(valid_vec)));

   // R5: the pointer moves only on a map command
   a_r5_rr_only_on_map: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && op_e == CMD_MAP) |=> $stable(rr_ptr));

   // R6: an accepted protect command adds exactly one valid slot
   a_r6_prot_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_e == CMD_PROT && !prot_bad)
         |=> $countones(valid_vec) == $past($countones(valid_vec)) + 1);

   // R7: the error flag follows only a protect command
   a_r7_err_after_prot: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err |-> $past(cmd_valid && op_e == CMD_PROT));

   // R8: a page purge removes at most one valid slot
   a_r8_purge_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_e == CMD_DROP_PAGE)
         |=> $countones(valid_vec) + 1 >= $past($countones(valid_vec)));

   // R9: purge-all leaves nothing valid
   a_r9_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_e == CMD_DROP_ALL) |=> valid_vec == '0);

   // R11: no command, no change
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(valid_vec) && $stable(rr_ptr));

endmodule

// File: tb/sim_range_tlb.sv
module sim_range_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit, lk_valid;
   logic [3:0]  lk_idx;
   logic [19:0] lk_ppn;
   logic [31:0] lk_paddr;
   logic [28:0] lk_prot;
   logic [31:0] lk_base, lk_limit;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_data = '0;
   logic        prot_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   range_tlb u0 (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
      .lk_paddr(lk_paddr), .lk_prot(lk_prot), .lk_base(lk_base), .lk_limit(lk_limit),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .prot_err(prot_err)
   );

   // reference state built from the requirements
   logic [31:0] m_lo   [16];
   logic [31:0] m_hi   [16];
   logic [19:0] m_ppn  [16];
   logic [28:0] m_prot [16];
   logic        m_val  [16];
   int          m_rr;

   task automatic m_clear(input int i);
      m_lo[i] = '1; m_hi[i] = '0; m_ppn[i] = '0; m_prot[i] = '0; m_val[i] = 1'b0;
   endtask

   function automatic int m_find(input logic [31:0] a);
      for (int i = 0; i < 16; i++)
         if (m_lo[i] <= a && a <= m_hi[i]) return i;
      return -1;
   endfunction

   task automatic m_apply(input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] d, output bit err);
      int k;
      int slot;
      err = 1'b0;
      case (op)
         2'd0: begin
            slot = -1;
            for (int i = 0; i < 16; i++) begin
               if (!m_val[i]) slot = i;
               else if (m_lo[i] <= a && a <= m_hi[i]) begin m_clear(i); slot = i; end
            end
            if (slot < 0) begin
               slot = m_rr;
               m_rr = (m_rr == 15) ? 0 : m_rr + 1;
            end
            m_clear(slot);
            m_lo[slot]  = a & 32'hFFFF_F000;
            m_hi[slot]  = m_lo[slot] + 32'd4095;
            m_ppn[slot] = d[24:5];
         end
         2'd1: begin
            k = m_find(a);
            if (k < 0 || m_val[k]) err = 1'b1;
            else begin m_prot[k] = d[29:1]; m_val[k] = 1'b1; end
         end
         2'd2: begin
            k = m_find(a);
            if (k >= 0 && m_val[k]) m_clear(k);
         end
         default: for (int i = 0; i < 16; i++) m_clear(i);
      endcase
   endtask

   task automatic check_lk(input logic [31:0] a, input string req);
      int k;
      logic        e_hit, e_val;
      logic [3:0]  e_idx;
      logic [19:0] e_ppn;
      logic [28:0] e_prot;
      logic [31:0] e_base, e_lim, e_pa;
      lk_addr = a;
      #1;
      k = m_find(a);
      e_hit = (k >= 0);
      e_idx = e_hit ? 4'(k) : 4'd0;
      e_val = e_hit ? m_val[k] : 1'b0;
      e_ppn = e_hit ? m_ppn[k] : '0;
      e_prot = e_hit ? m_prot[k] : '0;
      e_base = e_hit ? m_lo[k] : '0;
      e_lim = e_hit ? m_hi[k] : '0;
      e_pa = e_hit ? {m_ppn[k], a[11:0]} : '0;
      checks++;
      if (lk_hit !== e_hit || lk_valid !== e_val || lk_idx !== e_idx ||
          lk_ppn !== e_ppn || lk_prot !== e_prot || lk_base !== e_base ||
          lk_limit !== e_lim || lk_paddr !== e_pa) begin
         errors++;
         $display("FAIL %s addr=%h got hit=%b val=%b idx=%0d ppn=%h pa=%h prot=%h base=%h lim=%h exp hit=%b val=%b idx=%0d ppn=%h pa=%h prot=%h base=%h lim=%h",
                  req, a, lk_hit, lk_valid, lk_idx, lk_ppn, lk_paddr, lk_prot, lk_base, lk_limit,
                  e_hit, e_val, e_idx, e_ppn, e_pa, e_prot, e_base, e_lim);
      end
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] d, input string req);
      bit e_err;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      m_apply(op, a, d, e_err);
      checks++;
      if (prot_err !== e_err) begin
         errors++;
         $display("FAIL R7 (%s) prot_err got %b exp %b", req, prot_err, e_err);
      end
   endtask

   function automatic logic [31:0] ppn_word(input logic [19:0] p);
      return 32'hFE00_001F ^ {7'd0, p, 5'd0} ^ 32'h0000_0000;
   endfunction

   function automatic logic [31:0] prot_word(input int i);
      return 32'hA5C3_0000 ^ (32'(i) * 32'h0137_9BDF);
   endfunction

   initial begin
      logic [31:0] pa;
      for (int i = 0; i < 16; i++) m_clear(i);
      m_rr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R10: empty after reset
      checks++;
      if (prot_err !== 1'b0) begin errors++; $display("FAIL R1 prot_err got %b exp 0", prot_err); end
      check_lk(32'h0000_0000, "R1");
      check_lk(32'hFFFF_FFFF, "R10");
      check_lk(32'h1234_5678, "R1");

      // R3 / R4 / R6: fill, highest free slot first; pending slot is reused until protected
      for (int i = 0; i < 16; i++) begin
         pa = 32'h1000_0123 + 32'(i) * 32'h3000;
         do_cmd(2'd0, pa, ppn_word(20'h100 + 20'(i)), "R3");
         check_lk(pa, "R3");
         if (i == 0) begin
            do_cmd(2'd0, pa, ppn_word(20'h0AB), "R4");
            check_lk(pa, "R4");
         end
         do_cmd(2'd1, pa | 32'h0000_0FFF, prot_word(i), "R6");
         check_lk(pa, "R6");
      end

      // R2: window edges for every slot
      for (int i = 0; i < 16; i++) begin
         pa = 32'h1000_0000 + 32'(i) * 32'h3000;
         check_lk(pa, "R2");
         check_lk(pa + 32'h0FFF, "R2");
         check_lk(pa - 32'd1, "R2");
         check_lk(pa + 32'h1000, "R2");
      end

      // R7: protect on an empty window and on a valid slot
      do_cmd(2'd1, 32'h7000_0000, 32'h3FFF_FFFE, "R7");
      check_lk(32'h7000_0000, "R7");
      do_cmd(2'd1, 32'h1000_3010, 32'h3FFF_FFFE, "R7");
      check_lk(32'h1000_3010, "R7");

      // R11: idle with a purge-all opcode present
      @(negedge clk);
      cmd_op = 2'd3; cmd_addr = 32'h1000_0000;
      repeat (2) @(negedge clk);
      check_lk(32'h1000_0000, "R11");
      check_lk(32'h1002_D000, "R11");

      // R5: full buffer, evictions walk and wrap the pointer
      for (int i = 0; i < 18; i++) begin
         pa = 32'h4000_0000 + 32'(i) * 32'h1000;
         do_cmd(2'd0, pa, ppn_word(20'h900 + 20'(i)), "R5");
         check_lk(pa, "R5");
         do_cmd(2'd1, pa, prot_word(i + 40), "R5");
         check_lk(pa + 32'h800, "R5");
      end
      check_lk(32'h4000_0000, "R5");
      check_lk(32'h1000_0000, "R5");

      // R4: remap a valid page reuses its own slot
      do_cmd(2'd0, 32'h4000_5ABC, ppn_word(20'hBEEF0), "R4");
      check_lk(32'h4000_5000, "R4");
      do_cmd(2'd1, 32'h4000_5000, prot_word(77), "R4");
      // R8: page purge of valid slot frees it, then remap of another valid page picks the higher
      do_cmd(2'd2, 32'h4000_3004, 32'h0, "R8");
      check_lk(32'h4000_3004, "R8");
      do_cmd(2'd0, 32'h4000_C000, ppn_word(20'h55555), "R4");
      check_lk(32'h4000_C000, "R4");
      do_cmd(2'd1, 32'h4000_C000, prot_word(78), "R4");
      do_cmd(2'd0, 32'hFFFF_F123, ppn_word(20'hFFFFF), "R4");
      check_lk(32'hFFFF_FFFF, "R4");
      // R8: purge of a pending slot does nothing
      do_cmd(2'd2, 32'hFFFF_F000, 32'h0, "R8");
      check_lk(32'hFFFF_F000, "R8");
      do_cmd(2'd1, 32'hFFFF_FFFF, prot_word(99), "R6");
      check_lk(32'hFFFF_FFFF, "R6");
      do_cmd(2'd2, 32'h5000_0000, 32'h0, "R8");
      check_lk(32'h4000_C000, "R8");

      // R9 / R10: purge-all, leave a pending slot first
      do_cmd(2'd0, 32'h0000_0000, ppn_word(20'h00001), "R9");
      check_lk(32'h0000_0000, "R9");
      do_cmd(2'd3, 32'h0, 32'h0, "R9");
      check_lk(32'h0000_0000, "R9");
      check_lk(32'hFFFF_FFFF, "R10");
      check_lk(32'h4000_C000, "R9");
      do_cmd(2'd0, 32'h2000_0000, ppn_word(20'h00002), "R9");
      check_lk(32'h2000_0FFF, "R9");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule